// File: doc/BRIEF.md
# Single-Bit Register Set, Clear and Test Unit

This unit carries out the bit-oriented group of a small controller's instruction set against an external register file of 128 bytes. One 14-bit instruction word arrives with a one-cycle valid strobe. The word chooses a register, a bit position inside that byte and one of four actions. Two actions rewrite the chosen bit through a read-modify-write: one forces it low, the other forces it high, and the remaining seven bits come back unchanged. The other two actions only read the byte and raise a one-cycle skip request when the chosen bit matches the condition. The sequencer that owns the program counter uses that request to drop the next instruction.

The register file is outside the unit. The unit drives a read address and expects the read data back in the same cycle. It writes through a separate single-cycle write port. A three-state machine controls the work. ST_IDLE waits for a recognised word, and the transition on an accepted strobe is ACCEPT. ST_READ drives the read address and samples the byte. From there, transition TO_WRITE follows for the two rewriting actions and TEST_DONE, back to idle, follows for the two test actions. ST_WRITE drives the write port for one cycle, and transition WRITE_DONE returns to idle.

Top module: `bitop_unit`

## Requirements
- R1: Field layout: bits 13:12 equal to 01 mark a bit-group word, bits 11:10 select the action, bits 9:7 give the bit index and bits 6:0 give the register address. Any word whose bits 13:12 differ from 01 produces no write and no skip.
- R2: Action 00 (clear) writes the addressed byte back with the indexed bit at 0 and all other bits as read.
- R3: Action 01 (set) writes the addressed byte back with the indexed bit at 1 and all other bits as read.
- R4: Action 10 (test-clear) raises skip_req exactly when the indexed bit reads 0.
- R5: Action 11 (test-set) raises skip_req exactly when the indexed bit reads 1.
- R6: The test actions never assert rf_wr_en, and the set and clear actions never assert skip_req.
- R7: If instr_valid is accepted in cycle N, the register address appears on rf_rd_addr in cycle N+1. A write appears on rf_wr_en in cycle N+2, lasts one cycle and targets the address that was read. A skip pulse appears in cycle N+2 and lasts one cycle.
- R8: A strobe that arrives while the unit is not in ST_IDLE is dropped and causes no write of its own.
- R9: While reset is asserted and immediately after it is released, rf_wr_en and skip_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | One-cycle strobe qualifying instr_word |
| instr_word | input | 14 | Instruction word |
| rf_rd_addr | output | 7 | Register file read address |
| rf_rd_data | input | 8 | Register file read data, same-cycle |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_addr | output | 7 | Register file write address |
| rf_wr_data | output | 8 | Register file write data |
| skip_req | output | 1 | One-cycle request to skip the next instruction |

## Verification
The assertions assume that the register file returns the byte at rf_rd_addr combinationally, so that the data sampled in ST_READ is the data the write is built from. They also assume that instr_valid is a single-cycle strobe. The bench models the register file as a combinational-read array that it writes on rf_wr_en. It pulses the strobe for exactly one cycle per instruction. Its only extra strobes are placed deliberately inside the busy window to exercise R8.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bitop_state_e;

    // Action code; bit 1 distinguishes the test actions from the rewriting ones
    typedef enum logic [1:0] {
        ACT_CLR  = 2'b00,
        ACT_SET  = 2'b01,
        ACT_TCLR = 2'b10,
        ACT_TSET = 2'b11
    } bitop_act_e;

    localparam int unsigned GROUP_W    = 2;
    localparam logic [1:0]  GROUP_CODE = 2'b01;

    function automatic logic act_is_test(input bitop_act_e a);
        return a == ACT_TCLR || a == ACT_TSET;
    endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int unsigned INSTR_W = 14,
    parameter int unsigned ADDR_W  = 7,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [INSTR_W-1:0] word,
    output logic               hit,
    output bitop_act_e         act,
    output logic [IDX_W-1:0]   idx,
    output logic [ADDR_W-1:0]  addr
);
    localparam int unsigned IDX_LO = ADDR_W;
    localparam int unsigned ACT_LO = ADDR_W + IDX_W;
    localparam int unsigned GRP_LO = ACT_LO + 2;

    always_comb begin
        addr = word[ADDR_W-1:0];
        idx  = word[IDX_LO +: IDX_W];
        act  = bitop_act_e'(word[ACT_LO +: 2]);
        hit  = (word[GRP_LO +: GROUP_W] == GROUP_CODE);
    end
endmodule

// File: rtl/bitop_modify.sv
module bitop_modify #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [DATA_W-1:0] old_byte,
    input  logic [IDX_W-1:0]  idx,
    input  logic              force_val,
    output logic [DATA_W-1:0] new_byte,
    output logic              sel_bit
);
    logic [DATA_W-1:0] sel_mask;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sel_mask[i] = (idx == IDX_W'(i));
        assign new_byte[i] = sel_mask[i] ? force_val : old_byte[i];
    end

    assign sel_bit = |(old_byte & sel_mask);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int unsigned INSTR_W = 14,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [13:0]       instr_word,
    output logic [ADDR_W-1:0] rf_rd_addr,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [ADDR_W-1:0] rf_wr_addr,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              skip_req
);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    bitop_state_e      state_q, state_d;
    logic              dec_hit;
    bitop_act_e        dec_act, act_q;
    logic [IDX_W-1:0]  dec_idx, idx_q;
    logic [ADDR_W-1:0] dec_addr, addr_q;
    logic [DATA_W-1:0] mod_byte;
    logic              sel_bit;
    logic              accept;

    bitop_decode #(
        .INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_decode (
        .word(instr_word), .hit(dec_hit), .act(dec_act),
        .idx(dec_idx), .addr(dec_addr)
    );

    bitop_modify #(
        .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_modify (
        .old_byte(rf_rd_data), .idx(idx_q), .force_val(act_q == ACT_SET),
        .new_byte(mod_byte), .sel_bit(sel_bit)
    );

    assign accept = (state_q == ST_IDLE) && instr_valid && dec_hit;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_READ;                      // ACCEPT
            ST_READ:  state_d = act_is_test(act_q) ? ST_IDLE : ST_WRITE;  // TEST_DONE / TO_WRITE
            ST_WRITE: state_d = ST_IDLE;                                  // WRITE_DONE
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Field capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= ACT_CLR;
            idx_q  <= '0;
            addr_q <= '0;
        end else if (accept) begin
            act_q  <= dec_act;
            idx_q  <= dec_idx;
            addr_q <= dec_addr;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_wr_en   <= 1'b0;
            rf_wr_data <= '0;
            skip_req   <= 1'b0;
        end else begin
            rf_wr_en <= 1'b0;
            skip_req <= 1'b0;
            if (state_q == ST_READ) begin
                if (act_is_test(act_q)) begin
                    skip_req <= (act_q == ACT_TSET) ? sel_bit : ~sel_bit;
                end else begin
                    rf_wr_en   <= 1'b1;
                    rf_wr_data <= mod_byte;
                end
            end
        end
    end

    assign rf_rd_addr = addr_q;
    assign rf_wr_addr = addr_q;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [ADDR_W-1:0] rf_rd_addr,
    input logic [DATA_W-1:0] rf_rd_data,
    input logic              rf_wr_en,
    input logic [ADDR_W-1:0] rf_wr_addr,
    input logic [DATA_W-1:0] rf_wr_data,
    input logic              skip_req
);
    AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> !rf_wr_en); // R7
    AST_SKIP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |=> !skip_req); // R7
    AST_WR_SKIP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wr_en && skip_req)); // R6
    AST_WR_ONE_BIT_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> $countones(rf_wr_data ^ $past(rf_rd_data)) <= 1); // R2
    AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> rf_wr_addr == $past(rf_rd_addr)); // R7
    AST_WR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> $past(instr_valid, 2)); // R7
    AST_SKIP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> $past(instr_valid, 2)); // R7
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
    .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr),
    .rf_wr_data(rf_wr_data), .skip_req(skip_req)
);

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [13:0] instr_word = '0;
    logic [6:0] rf_rd_addr, rf_wr_addr;
    logic [7:0] rf_rd_data, rf_wr_data;
    logic       rf_wr_en, skip_req;

    logic [7:0] mem [128];
    int total = 0;
    int bad = 0;
    int wr_cnt = 0;

    always #5 clk = ~clk;

    bitop_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
        .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data), .skip_req(skip_req)
    );

    assign rf_rd_data = mem[rf_rd_addr];
    always @(posedge clk) if (rf_wr_en) begin
        mem[rf_wr_addr] <= rf_wr_data;
        wr_cnt <= wr_cnt + 1;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Starts at a falling edge; ends at the falling edge of the cycle after completion.
    task automatic run_bit(input int act, input int idx, input int addr, input int data,
                           input bit inject);
        int exp_byte;
        int bitv;
        int exp_skip;
        int wr_before;
        int nb;
        nb = (addr + 1) % 128;
        mem[addr] = 8'(data);
        mem[nb] = 8'h3C;
        wr_before = wr_cnt;
        instr_valid = 1'b1;
        instr_word = {2'b01, 2'(act), 3'(idx), 7'(addr)};
        @(negedge clk);                       // cycle N+1
        if (inject) begin
            instr_word = {2'b01, 2'b01, 3'd6, 7'(nb)};
            check(rf_rd_addr == 7'(addr), "R7 rd_addr", int'(rf_rd_addr), addr);
        end else begin
            instr_valid = 1'b0;
        end
        @(negedge clk);                       // cycle N+2
        instr_valid = 1'b0;
        bitv = (data >> idx) & 1;
        if (act < 2) begin
            exp_byte = (act == 1) ? (data | (1 << idx)) : (data & ~(1 << idx) & 8'hFF);
            check(rf_wr_en == 1'b1, "R7 wr_en", int'(rf_wr_en), 1);
            check(rf_wr_addr == 7'(addr), "R7 wr_addr", int'(rf_wr_addr), addr);
            check(rf_wr_data == 8'(exp_byte), (act == 1) ? "R3 set data" : "R2 clear data",
                  int'(rf_wr_data), exp_byte);
            check(skip_req == 1'b0, "R6 no skip", int'(skip_req), 0);
        end else begin
            exp_skip = (act == 3) ? bitv : 1 - bitv;
            check(skip_req == 1'(exp_skip), (act == 3) ? "R5 test-set" : "R4 test-clear",
                  int'(skip_req), exp_skip);
            check(rf_wr_en == 1'b0, "R6 no write", int'(rf_wr_en), 0);
        end
        @(negedge clk);                       // cycle N+3
        check(!rf_wr_en && !skip_req, "R7 single pulse", int'({rf_wr_en, skip_req}), 0);
        if (act < 2)
            check(mem[addr] == 8'(exp_byte), "R2 R3 stored", int'(mem[addr]), exp_byte);
        if (inject) begin
            check(mem[nb] == 8'h3C, "R8 busy strobe dropped", int'(mem[nb]), 8'h3C);
            check(wr_cnt - wr_before == ((act < 2) ? 1 : 0), "R8 write count",
                  wr_cnt - wr_before, (act < 2) ? 1 : 0);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'h00;
        @(negedge clk);
        check(!rf_wr_en && !skip_req, "R9 in reset", int'({rf_wr_en, skip_req}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rf_wr_en && !skip_req, "R9 after reset", int'({rf_wr_en, skip_req}), 0);

        // Exhaustive sweep: every action, bit index and byte value
        for (int act = 0; act < 4; act++)
            for (int idx = 0; idx < 8; idx++)
                for (int d = 0; d < 256; d++)
                    run_bit(act, idx, (d * 5 + idx + act * 37) % 128, d, (d % 16) == 3);

        // Words outside the bit group: R1
        for (int g = 0; g < 4; g++) begin
            if (g == 1) continue;
            for (int k = 0; k < 16; k++) begin
                int wb;
                wb = wr_cnt;
                instr_valid = 1'b1;
                instr_word = {2'(g), 2'(k % 4), 3'(k % 8), 7'(k * 9)};
                @(negedge clk);
                instr_valid = 1'b0;
                for (int c = 0; c < 3; c++) begin
                    check(!rf_wr_en && !skip_req, "R1 foreign word ignored",
                          int'({rf_wr_en, skip_req}), 0);
                    @(negedge clk);
                end
                check(wr_cnt == wb, "R1 no write", wr_cnt - wb, 0);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule